// File: doc/BRIEF.md
# USB Device Interrupt Status Register

This block holds the sticky event flags that a USB device controller raises to software. It keeps three flags in a single 32-bit status word. The frame flag records each start-of-frame marker. The suspend flag records a move from the active state into suspend. The NAK flag shows whether any endpoint has a pending NAK that is also enabled.

The frame flag also fires without a received marker. A frame-interval timer counts system clock cycles since the last frame event. When a marker is overdue by more than a small margin past its nominal interval, the timer raises the flag itself. The nominal interval is 1 ms at full speed and 125 µs at high speed. Each marker that does arrive restarts the timer, so the synthetic ticks stay aligned with the real traffic.

Software reads the word at any time. Writing a one clears the frame flag or the suspend flag. The NAK flag cannot be written: it follows the enabled endpoint NAK inputs and clears itself.

Top module: `usbd_irq_status`

## Requirements
- R1: After synchronous reset every bit of `stat_rdata` reads zero.
- R2: A one-cycle pulse on `sof_seen` sets `stat_rdata[7]` at the next clock edge. A write with `stat_wdata[7]=1` clears it at the next edge.
- R3: With `hs_mode=0` and no received marker, `stat_rdata[7]` sets on exactly the FS_LIM-th clock edge after the last frame event or after reset. FS_LIM = CLK_HZ/1000 + CLK_HZ·FS_MARGIN_NS/1e9 cycles.
- R4: With `hs_mode=1`, the same late tick happens on the HS_LIM-th edge. HS_LIM = CLK_HZ/8000 + CLK_HZ·HS_MARGIN_NS/1e9 cycles.
- R5: A received marker restarts the frame timer, so the next late tick is counted from that marker.
- R6: A pulse on `susp_enter` sets `stat_rdata[8]` at the next edge. A pulse on `susp_exit` alone clears it at the next edge.
- R7: A write with `stat_wdata[8]=1` clears `stat_rdata[8]`.
- R8: `stat_rdata[16]` is one, one edge after the inputs settle, exactly when some endpoint i has (`ep_tx_nak[i]` & `ep_tx_nak_en[i]`) | (`ep_rx_nak[i]` & `ep_rx_nak_en[i]`). It is zero otherwise.
- R9: Writes have no effect on `stat_rdata[16]`.
- R10: All bits other than 7, 8 and 16 read zero whatever is written.
- R11: When a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.

Default parameters are CLK_HZ = 60 MHz, FS_MARGIN_NS = 1500, HS_MARGIN_NS = 1000 and EP_NUM = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode | input | 1 | 0 selects full-speed frame timing, 1 selects high-speed |
| sof_seen | input | 1 | One-cycle pulse: frame marker received |
| susp_enter | input | 1 | One-cycle pulse: controller entered suspend |
| susp_exit | input | 1 | One-cycle pulse: controller left suspend |
| ep_tx_nak | input | EP_NUM | Per-endpoint transmit NAK flags |
| ep_tx_nak_en | input | EP_NUM | Per-endpoint transmit NAK enables |
| ep_rx_nak | input | EP_NUM | Per-endpoint receive NAK flags |
| ep_rx_nak_en | input | EP_NUM | Per-endpoint receive NAK enables |
| stat_we | input | 1 | Write strobe for the status word |
| stat_wdata | input | 32 | Write data; ones clear the matching sticky bits |
| stat_rdata | output | 32 | Current status word |

## Verification
The assertions take the event inputs to be single-cycle pulses. They also assume `hs_mode` is stable around the frame windows they check. The gap checker uses the larger, full-speed limit as its bound, so a speed change in mid-interval never makes it fire falsely. The bench drives every strobe for exactly one cycle at the falling edge. It changes `hs_mode` only together with a received marker, which restarts the timer. It also never raises `susp_enter` and `susp_exit` in the same cycle, so the suspend checks see one defined transition.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;
  localparam int STAT_W    = 32;
  localparam int SOF_POS   = 7;
  localparam int SUSP_POS  = 8;
  localparam int NAK_POS   = 16;

  localparam logic [STAT_W-1:0] LIVE_MASK =
    (STAT_W'(1) << SOF_POS) | (STAT_W'(1) << SUSP_POS) | (STAT_W'(1) << NAK_POS);

  // Cycles in a given span of nanoseconds at the given clock rate.
  function automatic int ns_to_cycles(input longint clk_hz, input longint ns);
    return int'((clk_hz * ns) / 64'd1_000_000_000);
  endfunction

  function automatic int frame_limit(input longint clk_hz, input longint per_sec,
                                     input longint margin_ns);
    return int'(clk_hz / per_sec) + ns_to_cycles(clk_hz, margin_ns);
  endfunction
endpackage

// File: rtl/frame_watch.sv
module frame_watch #(
  parameter int FS_LIM = 1000,
  parameter int HS_LIM = 125,
  localparam int CW = $clog2(FS_LIM + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_mode,
  input  logic sof_seen,
  output logic frame_evt
);
  localparam logic [CW-1:0] FS_TOP = CW'(FS_LIM - 1);
  localparam logic [CW-1:0] HS_TOP = CW'(HS_LIM - 1);

  logic [CW-1:0] gap_cnt;
  logic [CW-1:0] top_sel;
  logic          overdue;

  assign top_sel   = hs_mode ? HS_TOP : FS_TOP;
  assign overdue   = !sof_seen && (gap_cnt >= top_sel);
  assign frame_evt = sof_seen || overdue;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
    end else if (frame_evt) begin
      gap_cnt <= '0;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nak_reduce.sv
module nak_reduce #(
  parameter int EP_NUM = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EP_NUM-1:0] tx_nak,
  input  logic [EP_NUM-1:0] tx_en,
  input  logic [EP_NUM-1:0] rx_nak,
  input  logic [EP_NUM-1:0] rx_en,
  output logic              nak_any
);
  logic [EP_NUM-1:0] ep_hit;

  for (genvar g = 0; g < EP_NUM; g++) begin : g_ep
    assign ep_hit[g] = (tx_nak[g] & tx_en[g]) | (rx_nak[g] & rx_en[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) nak_any <= 1'b0;
    else     nak_any <= |ep_hit;
  end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic hw_clr,
  input  logic sw_clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)                    flag <= 1'b0;
    else if (set_evt)           flag <= 1'b1;
    else if (hw_clr || sw_clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/usbd_irq_status.sv
module usbd_irq_status
  import usbd_irq_pkg::*;
#(
  parameter int CLK_HZ       = 60_000_000,
  parameter int FS_MARGIN_NS = 1500,
  parameter int HS_MARGIN_NS = 1000,
  parameter int EP_NUM       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_mode,
  input  logic              sof_seen,
  input  logic              susp_enter,
  input  logic              susp_exit,
  input  logic [EP_NUM-1:0] ep_tx_nak,
  input  logic [EP_NUM-1:0] ep_tx_nak_en,
  input  logic [EP_NUM-1:0] ep_rx_nak,
  input  logic [EP_NUM-1:0] ep_rx_nak_en,
  input  logic              stat_we,
  input  logic [31:0]       stat_wdata,
  output logic [31:0]       stat_rdata
);
  localparam int FS_LIM = frame_limit(CLK_HZ, 1000, FS_MARGIN_NS);
  localparam int HS_LIM = frame_limit(CLK_HZ, 8000, HS_MARGIN_NS);

  logic frame_evt;
  logic sof_q, susp_q, nak_q;
  logic sof_w1c, susp_w1c;
  logic unused_wbits;

  assign sof_w1c      = stat_we && stat_wdata[SOF_POS];
  assign susp_w1c     = stat_we && stat_wdata[SUSP_POS];
  assign unused_wbits = ^{stat_wdata[31:SUSP_POS+1], stat_wdata[SOF_POS-1:0]};

  frame_watch #(.FS_LIM(FS_LIM), .HS_LIM(HS_LIM)) u_watch (
    .clk(clk), .rst(rst), .hs_mode(hs_mode),
    .sof_seen(sof_seen), .frame_evt(frame_evt)
  );

  sticky_flag u_sof (
    .clk(clk), .rst(rst), .set_evt(frame_evt),
    .hw_clr(1'b0), .sw_clr(sof_w1c), .flag(sof_q)
  );

  sticky_flag u_susp (
    .clk(clk), .rst(rst), .set_evt(susp_enter),
    .hw_clr(susp_exit), .sw_clr(susp_w1c), .flag(susp_q)
  );

  nak_reduce #(.EP_NUM(EP_NUM)) u_nak (
    .clk(clk), .rst(rst),
    .tx_nak(ep_tx_nak), .tx_en(ep_tx_nak_en),
    .rx_nak(ep_rx_nak), .rx_en(ep_rx_nak_en),
    .nak_any(nak_q)
  );

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[SOF_POS]  = sof_q;
    stat_rdata[SUSP_POS] = susp_q;
    stat_rdata[NAK_POS]  = nak_q;
  end
endmodule

// File: rtl/usbd_irq_status_chk.sv
module usbd_irq_status_chk #(
  parameter int EP_NUM = 4,
  parameter int FS_LIM = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              sof_seen,
  input logic              susp_enter,
  input logic              susp_exit,
  input logic [EP_NUM-1:0] ep_tx_nak,
  input logic [EP_NUM-1:0] ep_tx_nak_en,
  input logic [EP_NUM-1:0] ep_rx_nak,
  input logic [EP_NUM-1:0] ep_rx_nak_en,
  input logic              stat_we,
  input logic [31:0]       stat_wdata,
  input logic [31:0]       stat_rdata,
  input logic              frame_evt
);
  localparam int GW = $clog2(FS_LIM + 2);
  logic [GW-1:0] since_evt;
  logic          nak_need;

  assign nak_need = |((ep_tx_nak & ep_tx_nak_en) | (ep_rx_nak & ep_rx_nak_en));

  always_ff @(posedge clk) begin
    if (rst || frame_evt) since_evt <= '0;
    else                  since_evt <= since_evt + 1'b1;
  end

  // R2 R11
  sof_set_chk: assert property (@(posedge clk) disable iff (rst)
    sof_seen |=> stat_rdata[7]);
  // R2
  sof_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_we && stat_wdata[7] && !frame_evt) |=> !stat_rdata[7]);
  // R3
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    since_evt < GW'(FS_LIM));
  // R6 R11
  susp_set_chk: assert property (@(posedge clk) disable iff (rst)
    susp_enter |=> stat_rdata[8]);
  // R6
  susp_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (susp_exit && !susp_enter) |=> !stat_rdata[8]);
  // R8
  nak_on_chk: assert property (@(posedge clk) disable iff (rst)
    nak_need |=> stat_rdata[16]);
  // R8 R9
  nak_off_chk: assert property (@(posedge clk) disable iff (rst)
    !nak_need |=> !stat_rdata[16]);
  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(stat_rdata) <= 3 && (stat_rdata & ~32'h0001_0180) == '0);
endmodule

bind usbd_irq_status usbd_irq_status_chk #(.EP_NUM(EP_NUM), .FS_LIM(FS_LIM)) u_chk (
  .clk(clk), .rst(rst), .sof_seen(sof_seen), .susp_enter(susp_enter),
  .susp_exit(susp_exit), .ep_tx_nak(ep_tx_nak), .ep_tx_nak_en(ep_tx_nak_en),
  .ep_rx_nak(ep_rx_nak), .ep_rx_nak_en(ep_rx_nak_en), .stat_we(stat_we),
  .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .frame_evt(frame_evt)
);

// File: tb/sim_usbd_irq_status.sv
`timescale 1ns/1ps
module sim_usbd_irq_status;
  localparam int CLK_HZ = 2_000_000;
  localparam int EPN    = 4;
  // FS: 2000 + 3 cycles, HS: 250 + 2 cycles
  localparam int FS_L = CLK_HZ / 1000 + (CLK_HZ / 1000) * 1500 / 1_000_000;
  localparam int HS_L = CLK_HZ / 8000 + (CLK_HZ / 1000) * 1000 / 1_000_000;

  // {expected, tx_nak, tx_en, rx_nak, rx_en}
  localparam int NV = 8;
  localparam logic [16:0] NAK_VEC [NV] = '{
    {1'b0, 4'h0, 4'hF, 4'h0, 4'hF},
    {1'b1, 4'h1, 4'h1, 4'h0, 4'h0},
    {1'b0, 4'hF, 4'h0, 4'hF, 4'h0},
    {1'b1, 4'h0, 4'h0, 4'h8, 4'h8},
    {1'b0, 4'h5, 4'hA, 4'hA, 4'h5},
    {1'b1, 4'h4, 4'h6, 4'h0, 4'h0},
    {1'b0, 4'h0, 4'h0, 4'h0, 4'h0},
    {1'b1, 4'hF, 4'hF, 4'hF, 4'hF}
  };

  logic clk = 0, rst = 1, hs_mode = 0, sof_seen = 0, susp_enter = 0, susp_exit = 0;
  logic [EPN-1:0] txn = 0, txe = 0, rxn = 0, rxe = 0;
  logic stat_we = 0;
  logic [31:0] stat_wdata = 0, stat_rdata;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  usbd_irq_status #(.CLK_HZ(CLK_HZ), .EP_NUM(EPN)) u0 (
    .clk(clk), .rst(rst), .hs_mode(hs_mode), .sof_seen(sof_seen),
    .susp_enter(susp_enter), .susp_exit(susp_exit),
    .ep_tx_nak(txn), .ep_tx_nak_en(txe), .ep_rx_nak(rxn), .ep_rx_nak_en(rxe),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // advance n clock edges, sampling at the falling edge, pulses dropped after the first
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sof_seen = 0; susp_enter = 0; susp_exit = 0; stat_we = 0; stat_wdata = 0;
    end
  endtask

  task automatic w1c(input logic [31:0] d);
    stat_we = 1; stat_wdata = d;
  endtask

  initial begin
    #(8 * 190_000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset", stat_rdata, 32'h0);

    // R3: late tick counted from reset at full speed
    step(FS_L - 1);
    chk("R3 before limit", stat_rdata & 32'h80, 32'h0);
    step(1);
    chk("R3 at limit", stat_rdata & 32'h80, 32'h80);
    w1c(32'h80); step(1);
    chk("R2 w1c clears sof", stat_rdata & 32'h80, 32'h0);

    // R2 / R5: received marker sets bit and restarts timer
    sof_seen = 1; step(1);
    chk("R2 sof sets", stat_rdata & 32'h80, 32'h80);
    w1c(32'h80); step(1);
    step(FS_L - 2);
    chk("R5 no tick before resync limit", stat_rdata & 32'h80, 32'h0);
    step(1);
    chk("R5 tick after resync", stat_rdata & 32'h80, 32'h80);

    // R4: high speed interval
    hs_mode = 1; sof_seen = 1; step(1);
    w1c(32'h80); step(1);
    step(HS_L - 2);
    chk("R4 before hs limit", stat_rdata & 32'h80, 32'h0);
    step(1);
    chk("R4 at hs limit", stat_rdata & 32'h80, 32'h80);
    hs_mode = 0; sof_seen = 1; step(1);

    // R11: set and clear together on sof
    sof_seen = 1; w1c(32'h80); step(1);
    chk("R11 sof set beats clear", stat_rdata & 32'h80, 32'h80);

    // R6 / R7 / R11 suspend
    susp_enter = 1; step(1);
    chk("R6 suspend set", stat_rdata & 32'h100, 32'h100);
    susp_exit = 1; step(1);
    chk("R6 suspend exit clears", stat_rdata & 32'h100, 32'h0);
    susp_enter = 1; step(1);
    w1c(32'h100); step(1);
    chk("R7 suspend w1c", stat_rdata & 32'h100, 32'h0);
    susp_enter = 1; w1c(32'h100); step(1);
    chk("R11 suspend set beats clear", stat_rdata & 32'h100, 32'h100);

    // R8: NAK vector walk
    for (int v = 0; v < NV; v++) begin
      {txn, txe, rxn, rxe} = NAK_VEC[v][15:0];
      step(1);
      chk($sformatf("R8 nak vector %0d", v), 32'(stat_rdata[16]), 32'(NAK_VEC[v][16]));
    end

    // R9 / R10: writes cannot touch NAK or reserved bits
    w1c(32'hFFFF_FFFF); step(1);
    chk("R9 nak kept after write", stat_rdata & 32'h1_0000, 32'h1_0000);
    chk("R10 reserved bits zero", stat_rdata & ~32'h0001_0180, 32'h0);
    txn = 0; rxn = 0; w1c(32'h1_0000); step(1);
    chk("R8 nak self clears", stat_rdata & 32'h1_0000, 32'h0);
    susp_enter = 1; step(1);
    w1c(32'hFFFF_FE7F); step(1);
    chk("R10 write to other bits ignored", stat_rdata & ~32'h80, 32'h100);

    // R1: reset clears set bits
    txn = 4'h1; txe = 4'h1; step(2);
    rst = 1; step(1);
    chk("R1 reset clears all", stat_rdata, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule